// File: doc/BRIEF.md
# Memory Thermal Trip-Point Throttle Controller

This block watches a memory temperature value and turns it into a throttle decision for the memory scheduler. Three thresholds are programmable: warm, hot and critical. The highest threshold the temperature has reached selects the output. At warm or hot the block reports the throttle amount programmed for that level. At critical it raises a shutdown request that stays set until reset. The warm and hot levels each have a programmable hysteresis, so a level is left only when the temperature falls below its threshold minus its hysteresis.

The temperature comes from one of two sources, picked by a control bit. One is an external sensor reading. The other is an internal estimate built from memory traffic. The estimate is a saturating accumulator: each read command adds a read weight and each write command adds a write weight. Every fixed number of cycles it loses a fixed decay amount, and it never goes below zero. All thresholds, hysteresis values, throttle amounts, weights and the source bit are set through a small write-only register port. The scheduler logic that actually blocks commands is outside this block.

Top module: `mem_trip_throttle`

## Requirements
- R1: After reset, `throttle_level` is 0, `throttle_amt` is 0, `shutdown_req` is 0 and the activity estimate is 0. The reset thresholds are warm 85, hot 95 and critical 105, with zero hysteresis, and the external source is selected.
- R2: If the selected temperature sampled at a clock edge is at or above the warm threshold and below the hot threshold, then after that edge `throttle_level` is 1 and `throttle_amt` equals the warm amount.
- R3: If the sampled temperature is at or above the hot threshold and below the critical threshold, then after that edge `throttle_level` is 2 and `throttle_amt` equals the hot amount.
- R4: If the sampled temperature is at or above the critical threshold, then after that edge `shutdown_req` is 1, `throttle_level` is 3 and `throttle_amt` is all ones.
- R5: Once `shutdown_req` is set, it stays 1 until reset, and `throttle_level` stays 3. Falling temperature and register writes do not clear it.
- R6: A warm or hot level is kept while the temperature is at or above (threshold − hysteresis), with the subtraction floored at 0. When the temperature drops below the hot exit value, the block falls to warm if the temperature still meets the warm exit value, and to level 0 otherwise.
- R7: The level moves straight to the highest threshold reached in a single edge. For example, it goes from 0 to hot, or from 0 to critical, without passing through the levels in between.
- R8: Bit 0 of the control register selects the temperature source: 0 selects `temp_ext` and 1 selects the activity estimate. The source that is not selected has no effect on the outputs. `temp_used` shows the selected value.
- R9: At each clock edge the estimate adds the read weight when `rd_cmd` is 1 and the write weight when `wr_cmd` is 1. The result saturates at 2^TEMP_W − 1.
- R10: On every DECAY_PERIOD-th edge after reset (default 16), the estimate loses DECAY_AMT (default 4) after that edge's additions, with the result floored at 0.
- R11: Register map, with a write taking effect at the edge where `reg_wr_en` is 1:
  - Address 0: warm threshold in [7:0], warm hysteresis in [15:8].
  - Address 1: hot threshold in [7:0], hot hysteresis in [15:8].
  - Address 2: critical threshold in [7:0].
  - Address 3: warm amount in [3:0], hot amount in [7:4].
  - Address 4: source select in bit 0, read weight in [7:4], write weight in [11:8].
  - Writes to any other address change nothing.
- R12: The warm and hot amounts are independent. Rewriting the hot amount leaves the output of the warm level unchanged, and the new value is used once the hot level is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| temp_ext | input | 8 | External temperature reading |
| rd_cmd | input | 1 | A read command was issued this cycle |
| wr_cmd | input | 1 | A write command was issued this cycle |
| temp_used | output | 8 | Selected temperature value |
| throttle_level | output | 2 | 0 none, 1 warm, 2 hot, 3 critical |
| throttle_amt | output | 4 | Throttle amount for the current level |
| shutdown_req | output | 1 | Latched shutdown request |

## Verification
A wrong internal level shows up on `throttle_level` and `throttle_amt` at the first clock edge after the temperature crosses a threshold or a hysteresis boundary. The bench therefore samples one edge after each temperature step. A faulty estimate accumulator appears on `temp_used` at the edge after the bad update, or after the bad decay tick. The bench tracks this cycle by cycle against its own model of the weights and decay schedule. A shutdown latch that releases early shows as `shutdown_req` dropping on the first cold cycle or register write after it was raised.

// File: rtl/mtt_pkg.sv
package mtt_pkg;

    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_WARM = 2'd1,
        LVL_HOT  = 2'd2,
        LVL_CRIT = 2'd3
    } trip_lvl_e;

    // register addresses
    localparam int ADR_WARM = 0;
    localparam int ADR_HOT  = 1;
    localparam int ADR_CRIT = 2;
    localparam int ADR_AMT  = 3;
    localparam int ADR_CTRL = 4;

    // reset values
    localparam int RST_WARM_THR = 85;
    localparam int RST_HOT_THR  = 95;
    localparam int RST_CRIT_THR = 105;
    localparam int RST_WARM_AMT = 4;
    localparam int RST_HOT_AMT  = 8;
    localparam int RST_RD_WGT   = 1;
    localparam int RST_WR_WGT   = 2;

    // control field positions
    localparam int CTRL_SRC_BIT = 0;
    localparam int CTRL_RW_LSB  = 4;

endpackage

// File: rtl/mtt_regs.sv
module mtt_regs
    import mtt_pkg::*;
#(
    parameter int TEMP_W = 8,
    parameter int AMT_W  = 4,
    parameter int WGT_W  = 4,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [TEMP_W-1:0] warm_thr,
    output logic [TEMP_W-1:0] warm_hyst,
    output logic [TEMP_W-1:0] hot_thr,
    output logic [TEMP_W-1:0] hot_hyst,
    output logic [TEMP_W-1:0] crit_thr,
    output logic [AMT_W-1:0]  warm_amt,
    output logic [AMT_W-1:0]  hot_amt,
    output logic              src_est,
    output logic [WGT_W-1:0]  rd_wgt,
    output logic [WGT_W-1:0]  wr_wgt
);
    localparam int WW_LSB = CTRL_RW_LSB + WGT_W;

    typedef struct packed {
        logic [TEMP_W-1:0] warm_thr;
        logic [TEMP_W-1:0] warm_hyst;
        logic [TEMP_W-1:0] hot_thr;
        logic [TEMP_W-1:0] hot_hyst;
        logic [TEMP_W-1:0] crit_thr;
        logic [AMT_W-1:0]  warm_amt;
        logic [AMT_W-1:0]  hot_amt;
        logic              src_est;
        logic [WGT_W-1:0]  rd_wgt;
        logic [WGT_W-1:0]  wr_wgt;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (addr == ADDR_W'(ADR_WARM)) begin
                r_d.warm_thr  = wdata[TEMP_W-1:0];
                r_d.warm_hyst = wdata[2*TEMP_W-1:TEMP_W];
            end else if (addr == ADDR_W'(ADR_HOT)) begin
                r_d.hot_thr  = wdata[TEMP_W-1:0];
                r_d.hot_hyst = wdata[2*TEMP_W-1:TEMP_W];
            end else if (addr == ADDR_W'(ADR_CRIT)) begin
                r_d.crit_thr = wdata[TEMP_W-1:0];
            end else if (addr == ADDR_W'(ADR_AMT)) begin
                r_d.warm_amt = wdata[AMT_W-1:0];
                r_d.hot_amt  = wdata[2*AMT_W-1:AMT_W];
            end else if (addr == ADDR_W'(ADR_CTRL)) begin
                r_d.src_est = wdata[CTRL_SRC_BIT];
                r_d.rd_wgt  = wdata[CTRL_RW_LSB +: WGT_W];
                r_d.wr_wgt  = wdata[WW_LSB +: WGT_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.warm_thr  <= TEMP_W'(RST_WARM_THR);
            r_q.warm_hyst <= '0;
            r_q.hot_thr   <= TEMP_W'(RST_HOT_THR);
            r_q.hot_hyst  <= '0;
            r_q.crit_thr  <= TEMP_W'(RST_CRIT_THR);
            r_q.warm_amt  <= AMT_W'(RST_WARM_AMT);
            r_q.hot_amt   <= AMT_W'(RST_HOT_AMT);
            r_q.src_est   <= 1'b0;
            r_q.rd_wgt    <= WGT_W'(RST_RD_WGT);
            r_q.wr_wgt    <= WGT_W'(RST_WR_WGT);
        end else begin
            r_q <= r_d;
        end
    end

    assign warm_thr  = r_q.warm_thr;
    assign warm_hyst = r_q.warm_hyst;
    assign hot_thr   = r_q.hot_thr;
    assign hot_hyst  = r_q.hot_hyst;
    assign crit_thr  = r_q.crit_thr;
    assign warm_amt  = r_q.warm_amt;
    assign hot_amt   = r_q.hot_amt;
    assign src_est   = r_q.src_est;
    assign rd_wgt    = r_q.rd_wgt;
    assign wr_wgt    = r_q.wr_wgt;

endmodule

// File: rtl/mtt_estimator.sv
module mtt_estimator #(
    parameter int TEMP_W       = 8,
    parameter int WGT_W        = 4,
    parameter int DECAY_PERIOD = 16,
    parameter int DECAY_AMT    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_cmd,
    input  logic              wr_cmd,
    input  logic [WGT_W-1:0]  rd_wgt,
    input  logic [WGT_W-1:0]  wr_wgt,
    output logic [TEMP_W-1:0] est
);
    localparam int CNT_W = (DECAY_PERIOD > 1) ? $clog2(DECAY_PERIOD) : 1;
    localparam int SUM_W = TEMP_W + 2;
    localparam logic [SUM_W-1:0] SUM_MAX = {2'b00, {TEMP_W{1'b1}}};
    localparam logic [SUM_W-1:0] DEC     = SUM_W'(DECAY_AMT);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(DECAY_PERIOD - 1);

    typedef struct packed {
        logic [TEMP_W-1:0] acc;
        logic [CNT_W-1:0]  cnt;
    } est_t;

    est_t e_d, e_q;
    logic [SUM_W-1:0] grow, sat, shrunk;
    logic             tick;

    always_comb begin
        e_d  = e_q;
        tick = (e_q.cnt == CNT_TOP);
        grow = {2'b00, e_q.acc}
             + (rd_cmd ? SUM_W'(rd_wgt) : '0)
             + (wr_cmd ? SUM_W'(wr_wgt) : '0);
        sat    = (grow > SUM_MAX) ? SUM_MAX : grow;
        shrunk = (sat > DEC) ? (sat - DEC) : '0;
        e_d.acc = tick ? shrunk[TEMP_W-1:0] : sat[TEMP_W-1:0];
        e_d.cnt = tick ? '0 : e_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q <= '0;
        end else begin
            e_q <= e_d;
        end
    end

    assign est = e_q.acc;

endmodule

// File: rtl/mtt_trip_eval.sv
module mtt_trip_eval
    import mtt_pkg::*;
#(
    parameter int TEMP_W = 8,
    parameter int AMT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp,
    input  logic [TEMP_W-1:0] warm_thr,
    input  logic [TEMP_W-1:0] warm_hyst,
    input  logic [TEMP_W-1:0] hot_thr,
    input  logic [TEMP_W-1:0] hot_hyst,
    input  logic [TEMP_W-1:0] crit_thr,
    input  logic [AMT_W-1:0]  warm_amt,
    input  logic [AMT_W-1:0]  hot_amt,
    output trip_lvl_e         level,
    output logic [AMT_W-1:0]  amt,
    output logic              shutdown
);
    localparam int NLVL = 2; // index 0 warm, 1 hot

    typedef struct packed {
        trip_lvl_e level;
        logic      shut;
    } trip_t;

    trip_t t_d, t_q;

    logic [NLVL-1:0][TEMP_W-1:0] thr_a, hyst_a, exit_a;
    logic [NLVL-1:0]             enter_ok, stay_ok;

    assign thr_a[0]  = warm_thr;
    assign thr_a[1]  = hot_thr;
    assign hyst_a[0] = warm_hyst;
    assign hyst_a[1] = hot_hyst;

    for (genvar g = 0; g < NLVL; g++) begin : g_band
        assign exit_a[g]   = (hyst_a[g] > thr_a[g]) ? '0 : (thr_a[g] - hyst_a[g]);
        assign enter_ok[g] = (temp >= thr_a[g]);
        assign stay_ok[g]  = (temp >= exit_a[g]);
    end

    always_comb begin
        t_d = t_q;
        if (t_q.shut || (temp >= crit_thr)) begin
            t_d.shut  = 1'b1;
            t_d.level = LVL_CRIT;
        end else if (enter_ok[1] || ((t_q.level == LVL_HOT) && stay_ok[1])) begin
            t_d.level = LVL_HOT;
        end else if (enter_ok[0] ||
                     (((t_q.level == LVL_HOT) || (t_q.level == LVL_WARM)) && stay_ok[0])) begin
            t_d.level = LVL_WARM;
        end else begin
            t_d.level = LVL_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q.level <= LVL_NONE;
            t_q.shut  <= 1'b0;
        end else begin
            t_q <= t_d;
        end
    end

    always_comb begin
        unique case (t_q.level)
            LVL_WARM: amt = warm_amt;
            LVL_HOT:  amt = hot_amt;
            LVL_CRIT: amt = '1;
            default:  amt = '0;
        endcase
    end

    assign level    = t_q.level;
    assign shutdown = t_q.shut;

endmodule

// File: rtl/mem_trip_throttle.sv
module mem_trip_throttle
    import mtt_pkg::*;
#(
    parameter int TEMP_W       = 8,
    parameter int AMT_W        = 4,
    parameter int WGT_W        = 4,
    parameter int ADDR_W       = 4,
    parameter int DATA_W       = 16,
    parameter int DECAY_PERIOD = 16,
    parameter int DECAY_AMT    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [TEMP_W-1:0] temp_ext,
    input  logic              rd_cmd,
    input  logic              wr_cmd,
    output logic [TEMP_W-1:0] temp_used,
    output logic [1:0]        throttle_level,
    output logic [AMT_W-1:0]  throttle_amt,
    output logic              shutdown_req
);
    logic [TEMP_W-1:0] warm_thr, warm_hyst, hot_thr, hot_hyst, crit_thr;
    logic [AMT_W-1:0]  warm_amt, hot_amt;
    logic              src_est;
    logic [WGT_W-1:0]  rd_wgt, wr_wgt;
    logic [TEMP_W-1:0] est_temp;
    trip_lvl_e         lvl;

    mtt_regs #(
        .TEMP_W(TEMP_W), .AMT_W(AMT_W), .WGT_W(WGT_W),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata),
        .warm_thr(warm_thr), .warm_hyst(warm_hyst), .hot_thr(hot_thr), .hot_hyst(hot_hyst),
        .crit_thr(crit_thr), .warm_amt(warm_amt), .hot_amt(hot_amt), .src_est(src_est),
        .rd_wgt(rd_wgt), .wr_wgt(wr_wgt)
    );

    mtt_estimator #(
        .TEMP_W(TEMP_W), .WGT_W(WGT_W),
        .DECAY_PERIOD(DECAY_PERIOD), .DECAY_AMT(DECAY_AMT)
    ) u_est (
        .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd),
        .rd_wgt(rd_wgt), .wr_wgt(wr_wgt), .est(est_temp)
    );

    assign temp_used = src_est ? est_temp : temp_ext;

    mtt_trip_eval #(
        .TEMP_W(TEMP_W), .AMT_W(AMT_W)
    ) u_trip (
        .clk(clk), .rst_n(rst_n), .temp(temp_used),
        .warm_thr(warm_thr), .warm_hyst(warm_hyst), .hot_thr(hot_thr), .hot_hyst(hot_hyst),
        .crit_thr(crit_thr), .warm_amt(warm_amt), .hot_amt(hot_amt),
        .level(lvl), .amt(throttle_amt), .shutdown(shutdown_req)
    );

    assign throttle_level = lvl;

endmodule

// File: rtl/mtt_checker.sv
module mtt_checker #(
    parameter int TEMP_W = 8,
    parameter int AMT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_cmd,
    input logic              wr_cmd,
    input logic [TEMP_W-1:0] est_temp,
    input logic [TEMP_W-1:0] temp_used,
    input logic [TEMP_W-1:0] crit_thr,
    input logic [1:0]        throttle_level,
    input logic [AMT_W-1:0]  throttle_amt,
    input logic              shutdown_req
);
    // R5: shutdown never releases before reset
    p_shutdown_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |=> shutdown_req);

    // R4: shutdown implies critical level and full throttle
    p_crit_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |-> (throttle_level == 2'd3) && (throttle_amt == {AMT_W{1'b1}}));

    // R4: shutdown only rises after a sample at or above the critical threshold
    p_crit_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shutdown_req) |-> ($past(temp_used) >= $past(crit_thr)));

    // R10: with no commands the estimate never grows
    p_est_no_growth_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_cmd && !wr_cmd) |=> (est_temp <= $past(est_temp)));

    // R1: level 0 reports no throttle
    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (throttle_level == 2'd0) |-> (throttle_amt == '0));

endmodule

bind mem_trip_throttle mtt_checker #(.TEMP_W(TEMP_W), .AMT_W(AMT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd),
    .est_temp(est_temp), .temp_used(temp_used), .crit_thr(crit_thr),
    .throttle_level(throttle_level), .throttle_amt(throttle_amt),
    .shutdown_req(shutdown_req)
);

// File: tb/tb_mem_trip_throttle.sv
`timescale 1ns/1ps
module tb_mem_trip_throttle;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [7:0]  temp_ext = '0;
    logic        rd_cmd = 1'b0;
    logic        wr_cmd = 1'b0;
    logic [7:0]  temp_used;
    logic [1:0]  throttle_level;
    logic [3:0]  throttle_amt;
    logic        shutdown_req;

    always #2.5 clk = ~clk;

    mem_trip_throttle dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .temp_ext(temp_ext), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd),
        .temp_used(temp_used), .throttle_level(throttle_level),
        .throttle_amt(throttle_amt), .shutdown_req(shutdown_req)
    );

    typedef struct {
        int    due;
        string req;
        int    kind;  // 0 outputs, 1 temp vs model, 2 temp vs value
        int    lvl;
        int    amt;
        int    sd;
        int    tmp;
    } item_t;

    item_t q[$];
    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // estimate model from R9/R10
    int m_acc = 0;
    int m_n = 0;
    int sh_rw = 1;
    int sh_ww = 2;
    always @(posedge clk) begin
        int s;
        if (!rst_n) begin
            m_acc <= 0; m_n <= 0; sh_rw <= 1; sh_ww <= 2;
        end else begin
            s = m_acc + (rd_cmd ? sh_rw : 0) + (wr_cmd ? sh_ww : 0);
            if (s > 255) s = 255;
            if ((m_n % 16) == 15) s = (s > 4) ? s - 4 : 0;
            m_acc <= s;
            m_n <= m_n + 1;
            if (reg_wr_en && reg_addr == 4'd4) begin
                sh_rw <= int'(reg_wdata[7:4]);
                sh_ww <= int'(reg_wdata[11:8]);
            end
        end
    end

    // monitor
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (it.kind == 0) begin
                if (int'(throttle_level) != it.lvl || int'(throttle_amt) != it.amt ||
                    int'(shutdown_req) != it.sd) begin
                    errors++;
                    $display("FAIL %s: lvl/amt/sd = %0d/%0d/%0d expected %0d/%0d/%0d",
                             it.req, throttle_level, throttle_amt, shutdown_req,
                             it.lvl, it.amt, it.sd);
                end
            end else begin
                int exp_t;
                exp_t = (it.kind == 1) ? m_acc : it.tmp;
                if (int'(temp_used) != exp_t) begin
                    errors++;
                    $display("FAIL %s: temp_used = %0d expected %0d", it.req, temp_used, exp_t);
                end
            end
        end
    end

    task automatic push(int due, string req, int kind, int lvl, int amt, int sd, int tmp);
        item_t it;
        it.due = due; it.req = req; it.kind = kind;
        it.lvl = lvl; it.amt = amt; it.sd = sd; it.tmp = tmp;
        q.push_back(it);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_reg(int a, int d);
        reg_wr_en = 1'b1; reg_addr = 4'(a); reg_wdata = 16'(d);
        tick();
        reg_wr_en = 1'b0;
    endtask

    task automatic step_ext(int t, string req, int lvl, int amt, int sd);
        temp_ext = 8'(t);
        push(cyc + 1, req, 0, lvl, amt, sd, 0);
        tick();
    endtask

    task automatic step_est(bit rd, bit wr, string req);
        rd_cmd = rd; wr_cmd = wr;
        push(cyc + 1, req, 1, 0, 0, 0, 0);
        tick();
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) tick();
        rst_n = 1'b1;
        push(cyc, "R1", 0, 0, 0, 0, 0);
        push(cyc, "R1", 2, 0, 0, 0, 0);
        tick();

        // R11 programming
        wr_reg(0, 16'h0532);   // warm 50, hyst 5
        wr_reg(1, 16'h0A50);   // hot 80, hyst 10
        wr_reg(2, 16'h0078);   // crit 120
        wr_reg(3, 16'h0093);   // warm amt 3, hot amt 9
        wr_reg(4, 16'h0520);   // ext source, rd w 2, wr w 5
        wr_reg(9, 16'h0000);   // unmapped: must change nothing (R11)

        step_ext(40, "R2", 0, 0, 0);
        step_ext(60, "R2 R11", 1, 3, 0);
        step_ext(49, "R6", 1, 3, 0);
        step_ext(44, "R6", 0, 0, 0);
        step_ext(90, "R3 R7", 2, 9, 0);
        step_ext(75, "R6", 2, 9, 0);
        step_ext(65, "R6", 1, 3, 0);

        wr_reg(3, 16'h00C3);   // hot amt 12
        push(cyc, "R12", 0, 1, 3, 0, 0);
        step_ext(90, "R12", 2, 12, 0);

        // R8: switch to estimate, external 90 ignored
        wr_reg(4, 16'h0521);
        push(cyc + 1, "R8", 0, 0, 0, 0, 0);
        push(cyc + 1, "R8", 1, 0, 0, 0, 0);
        tick();
        for (int i = 0; i < 3; i++) step_est(1'b1, 1'b0, "R9");
        for (int i = 0; i < 3; i++) step_est(1'b1, 1'b1, "R9");
        rd_cmd = 1'b0; wr_cmd = 1'b0;
        push(cyc, "R8", 0, 0, 0, 0, 0);
        tick();

        // back to external, direct jump to critical
        wr_reg(4, 16'h0520);
        step_ext(130, "R4 R7", 3, 15, 1);
        step_ext(0, "R5", 3, 15, 1);
        wr_reg(2, 16'h00FF);
        push(cyc, "R5", 0, 3, 15, 1, 0);
        tick();

        // saturation with max weights, estimate source
        wr_reg(4, 16'h0FF1);
        for (int i = 0; i < 14; i++) step_est(1'b1, 1'b1, "R9");
        for (int i = 0; i < 20; i++) step_est(1'b0, 1'b0, "R10");
        rd_cmd = 1'b0; wr_cmd = 1'b0;
        repeat (1100) tick();
        push(cyc, "R10", 2, 0, 0, 0, 0);
        push(cyc, "R5", 0, 3, 15, 1, 0);
        tick();
        tick();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule